// File: doc/BRIEF.md
# Remote Wakeup Resume Sequencer

This block finishes a host port resume once the system has come back up because an attached device signalled a remote wakeup. It sits between the host controller's port status, a free-running microsecond tick and the pad-side line controls. It walks a fixed sequence: confirm the port entered resume, hand the pads back from the wake detector, let the resume interval elapse, clear stale status, wait for the first start-of-frame and finally undo the line override that kept the bus quiet during wakeup.

A wake event arms the block through a one-cycle set pulse that raises an internal remote-wake flag. A start pulse then launches the sequence. With the flag clear, the start pulse is answered by an immediate done pulse and nothing else moves. Every waiting step is measured in microsecond ticks with a parameterised length, so simulation can shorten the long resume interval. Both waits that can fail, the one for the port resume bit and the one for the first frame, end in a timeout reported on a sticky status output.

Top module: `rwk_resume_seq`

## Requirements
- R1: When the start pulse arrives with the remote-wake flag clear, done is high in the following cycle. No pad release, clear pulse, override or pulldown output is raised.
- R2: With the flag set, the port resume input is sampled on each tick for at most RES_POLLS ticks. If it is never seen high, resume_to_o is set and done pulses. There is then no pad release and no clear pulse, and the override and pulldown outputs keep their values.
- R3: When the resume input is seen high on a tick, pad_release_o pulses for exactly one cycle. This pulse comes before any other step of the sequence.
- R4: After the pad release pulse, exactly SETTLE_US ticks elapse before the status clear.
- R5: The status clear raises clr_pchg_o (port-change status, bit 2) and clr_sof_o (frame-received status, bit 7) together for a single cycle, once per sequence.
- R6: After the clear, the frame wait ends on the first tick on which sof_seen_i is high. If SOF_WAIT_US ticks pass without it, sof_to_o is set and the sequence continues anyway. The post-resume step starts two cycles after the tick that ends the wait.
- R7: On a port that is not low-speed, a start with the flag set raises obs_ovr_o and pulldn_o, and they stay high through the frame wait. In the post-resume step, obs_se0_o is held for SE0_US ticks. Then the override drops while the pulldowns are still forced, and the pulldowns drop in the next cycle, together with done.
- R8: On a low-speed port (low_speed_i = 1), obs_ovr_o and obs_se0_o are never raised and the post-resume step is skipped. Done follows the frame wait directly.
- R9: wake_set_i raises wake_flag_o in the next cycle. Each sequence ends with a single-cycle done pulse, after which wake_flag_o is low.
- R10: While rst_n is low, every output is low.
- R11: resume_to_o and sof_to_o stay set after the sequence ends. They are cleared by the next start accepted with the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_set_i | input | 1 | Pulse: a remote wake was detected, sets the flag |
| go_i | input | 1 | Pulse: start the resume completion |
| low_speed_i | input | 1 | Attached device is low-speed |
| port_resume_i | input | 1 | Port resume status bit from the host controller |
| sof_seen_i | input | 1 | Frame-received status bit from the host controller |
| usec_tick_i | input | 1 | One-cycle pulse per microsecond |
| pad_release_o | output | 1 | Pulse: wake detector must give up pad control |
| clr_pchg_o | output | 1 | Write-one-to-clear pulse for port-change status |
| clr_sof_o | output | 1 | Write-one-to-clear pulse for frame-received status |
| obs_ovr_o | output | 1 | Line observe override active |
| obs_se0_o | output | 1 | Override drives SE0 |
| pulldn_o | output | 1 | D+/D- pulldowns and termination overrides forced |
| done_o | output | 1 | Pulse: return to idle |
| wake_flag_o | output | 1 | Remote-wake flag |
| resume_to_o | output | 1 | Sticky: port resume bit never seen |
| sof_to_o | output | 1 | Sticky: first frame never seen |

## Verification
The sweep varies the tick on which the resume bit first appears across the whole poll window and one tick past it. This separates an accepted resume at the last poll from an abort. Independently, it moves the frame arrival from the first tick of its wait to past the timeout, which checks both the exit on arrival and the forced continuation. Each point runs for full-speed and low-speed ports, to tell the override path from the skipped one, and with a tick on every cycle and on every third cycle, to show that all waits count ticks rather than clocks. Separate short runs cover a start without the flag and the survival of a sticky timeout until the next accepted start.

// File: rtl/rwk_pkg.sv
package rwk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_POLL    = 4'd1,
    ST_FREE    = 4'd2,
    ST_SETTLE  = 4'd3,
    ST_CLEAR   = 4'd4,
    ST_SOFW    = 4'd5,
    ST_POST    = 4'd6,
    ST_SE0     = 4'd7,
    ST_OVR_OFF = 4'd8,
    ST_FIN     = 4'd9
  } rwk_state_e;

  typedef struct packed {
    logic arm_full;
    logic arm_low;
    logic se0_on;
    logic ovr_off;
    logic pd_off;
  } rwk_line_cmd_t;

endpackage

// File: rtl/rwk_us_timer.sv
module rwk_us_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] lim_i,
  output logic          hit_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = tick_i && (cnt_q == (lim_i - CW'(1)));

  // R4
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_i);

endmodule

// File: rtl/rwk_line_ovr.sv
module rwk_line_ovr
  import rwk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  rwk_line_cmd_t cmd_i,
  output logic          ovr_o,
  output logic          se0_o,
  output logic          pd_o
);

  logic ovr_q, se0_q, pd_q;
  logic ovr_d, se0_d, pd_d;

  always_comb begin
    ovr_d = ovr_q;
    se0_d = se0_q;
    pd_d  = pd_q;
    if (cmd_i.arm_full) begin
      ovr_d = 1'b1;
      pd_d  = 1'b1;
      se0_d = 1'b0;
    end
    if (cmd_i.arm_low) begin
      se0_d = 1'b0;
    end
    if (cmd_i.se0_on) begin
      se0_d = 1'b1;
    end
    if (cmd_i.ovr_off) begin
      ovr_d = 1'b0;
      se0_d = 1'b0;
    end
    if (cmd_i.pd_off) begin
      pd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      se0_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      se0_q <= se0_d;
      pd_q  <= pd_d;
    end
  end

  assign ovr_o = ovr_q;
  assign se0_o = se0_q;
  assign pd_o  = pd_q;

  // R8
  se0_needs_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    se0_q |-> ovr_q);

  // R7
  pd_after_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_q) |-> pd_q);

endmodule

// File: rtl/rwk_seq_fsm.sv
module rwk_seq_fsm
  import rwk_pkg::*;
#(
  parameter int RES_POLLS   = 3000,
  parameter int SETTLE_US   = 25000,
  parameter int SOF_WAIT_US = 1000,
  parameter int SE0_US      = 3,
  parameter int CW          = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake_set_i,
  input  logic          go_i,
  input  logic          low_speed_i,
  input  logic          port_resume_i,
  input  logic          sof_seen_i,
  input  logic          usec_tick_i,
  input  logic          hit_i,
  input  logic          ovr_i,
  output logic          cnt_clr_o,
  output logic [CW-1:0] lim_o,
  output rwk_line_cmd_t cmd_o,
  output logic          pad_release_o,
  output logic          clr_pchg_o,
  output logic          clr_sof_o,
  output logic          done_o,
  output logic          wake_flag_o,
  output logic          resume_to_o,
  output logic          sof_to_o
);

  rwk_state_e st_q, st_d;
  logic flag_q, flag_d;
  logic res_to_q, res_to_d;
  logic sof_to_q, sof_to_d;
  logic run;

  always_comb begin
    st_d     = st_q;
    flag_d   = flag_q;
    res_to_d = res_to_q;
    sof_to_d = sof_to_q;
    cmd_o    = '0;
    lim_o    = CW'(1);
    run      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          if (flag_q) begin
            st_d     = ST_POLL;
            res_to_d = 1'b0;
            sof_to_d = 1'b0;
            if (low_speed_i) begin
              cmd_o.arm_low = 1'b1;
            end else begin
              cmd_o.arm_full = 1'b1;
            end
          end else begin
            st_d = ST_FIN;
          end
        end
      end
      ST_POLL: begin
        run   = 1'b1;
        lim_o = CW'(RES_POLLS);
        if (usec_tick_i && port_resume_i) begin
          st_d = ST_FREE;
        end else if (hit_i) begin
          res_to_d = 1'b1;
          st_d     = ST_FIN;
        end
      end
      ST_FREE: begin
        st_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        run   = 1'b1;
        lim_o = CW'(SETTLE_US);
        if (hit_i) begin
          st_d = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        st_d = ST_SOFW;
      end
      ST_SOFW: begin
        run   = 1'b1;
        lim_o = CW'(SOF_WAIT_US);
        if (usec_tick_i && sof_seen_i) begin
          st_d = ST_POST;
        end else if (hit_i) begin
          sof_to_d = 1'b1;
          st_d     = ST_POST;
        end
      end
      ST_POST: begin
        if (ovr_i) begin
          cmd_o.se0_on = 1'b1;
          st_d         = ST_SE0;
        end else begin
          st_d = ST_FIN;
        end
      end
      ST_SE0: begin
        run   = 1'b1;
        lim_o = CW'(SE0_US);
        if (hit_i) begin
          cmd_o.ovr_off = 1'b1;
          st_d          = ST_OVR_OFF;
        end
      end
      ST_OVR_OFF: begin
        cmd_o.pd_off = 1'b1;
        st_d         = ST_FIN;
      end
      ST_FIN: begin
        flag_d = 1'b0;
        st_d   = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
    if (wake_set_i) begin
      flag_d = 1'b1;
    end
    cnt_clr_o = !run || (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      flag_q   <= 1'b0;
      res_to_q <= 1'b0;
      sof_to_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      flag_q   <= flag_d;
      res_to_q <= res_to_d;
      sof_to_q <= sof_to_d;
    end
  end

  assign pad_release_o = (st_q == ST_FREE);
  assign clr_pchg_o    = (st_q == ST_CLEAR);
  assign clr_sof_o     = (st_q == ST_CLEAR);
  assign done_o        = (st_q == ST_FIN);
  assign wake_flag_o   = flag_q;
  assign resume_to_o   = res_to_q;
  assign sof_to_o      = sof_to_q;

  // R1
  noflag_quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && go_i && !flag_q) |=> done_o);

  // R2
  abort_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_to_q) |-> done_o);

  // R3
  release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_release_o |=> !pad_release_o);

  // R5
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pchg_o |=> !clr_pchg_o);

  // R6
  sof_to_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_to_q) |-> (st_q == ST_POST));

  // R9
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wake_set_i) |=> !wake_flag_o);

endmodule

// File: rtl/rwk_resume_seq.sv
module rwk_resume_seq
  import rwk_pkg::*;
#(
  parameter int RES_POLLS   = 3000,
  parameter int SETTLE_US   = 25000,
  parameter int SOF_WAIT_US = 1000,
  parameter int SE0_US      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_set_i,
  input  logic go_i,
  input  logic low_speed_i,
  input  logic port_resume_i,
  input  logic sof_seen_i,
  input  logic usec_tick_i,
  output logic pad_release_o,
  output logic clr_pchg_o,
  output logic clr_sof_o,
  output logic obs_ovr_o,
  output logic obs_se0_o,
  output logic pulldn_o,
  output logic done_o,
  output logic wake_flag_o,
  output logic resume_to_o,
  output logic sof_to_o
);

  localparam int MAX_A = (RES_POLLS > SETTLE_US) ? RES_POLLS : SETTLE_US;
  localparam int MAX_B = (SOF_WAIT_US > SE0_US) ? SOF_WAIT_US : SE0_US;
  localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_L + 1);

  logic          cnt_clr;
  logic [CW-1:0] lim;
  logic          hit;
  rwk_line_cmd_t line_cmd;

  rwk_us_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .tick_i (usec_tick_i),
    .lim_i  (lim),
    .hit_o  (hit)
  );

  rwk_line_ovr u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_i (line_cmd),
    .ovr_o (obs_ovr_o),
    .se0_o (obs_se0_o),
    .pd_o  (pulldn_o)
  );

  rwk_seq_fsm #(
    .RES_POLLS   (RES_POLLS),
    .SETTLE_US   (SETTLE_US),
    .SOF_WAIT_US (SOF_WAIT_US),
    .SE0_US      (SE0_US),
    .CW          (CW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wake_set_i    (wake_set_i),
    .go_i          (go_i),
    .low_speed_i   (low_speed_i),
    .port_resume_i (port_resume_i),
    .sof_seen_i    (sof_seen_i),
    .usec_tick_i   (usec_tick_i),
    .hit_i         (hit),
    .ovr_i         (obs_ovr_o),
    .cnt_clr_o     (cnt_clr),
    .lim_o         (lim),
    .cmd_o         (line_cmd),
    .pad_release_o (pad_release_o),
    .clr_pchg_o    (clr_pchg_o),
    .clr_sof_o     (clr_sof_o),
    .done_o        (done_o),
    .wake_flag_o   (wake_flag_o),
    .resume_to_o   (resume_to_o),
    .sof_to_o      (sof_to_o)
  );

endmodule

// File: tb/test_rwk_resume_seq.sv
`timescale 1ns/1ps
module test_rwk_resume_seq;

  localparam int RES = 6;
  localparam int SET = 9;
  localparam int SFW = 5;
  localparam int SEH = 3;

  logic clk;
  logic rst_n;
  logic wake_set, go, ls, presume, sof, tick;
  logic pad_release_o, clr_pchg_o, clr_sof_o, obs_ovr_o, obs_se0_o, pulldn_o;
  logic done_o, wake_flag_o, resume_to_o, sof_to_o;

  int total;
  int bad;

  rwk_resume_seq #(
    .RES_POLLS(RES), .SETTLE_US(SET), .SOF_WAIT_US(SFW), .SE0_US(SEH)
  ) i_rwk_resume_seq (
    .clk(clk), .rst_n(rst_n), .wake_set_i(wake_set), .go_i(go),
    .low_speed_i(ls), .port_resume_i(presume), .sof_seen_i(sof),
    .usec_tick_i(tick), .pad_release_o(pad_release_o),
    .clr_pchg_o(clr_pchg_o), .clr_sof_o(clr_sof_o), .obs_ovr_o(obs_ovr_o),
    .obs_se0_o(obs_se0_o), .pulldn_o(pulldn_o), .done_o(done_o),
    .wake_flag_o(wake_flag_o), .resume_to_o(resume_to_o), .sof_to_o(sof_to_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; go = 0; wake_set = 0; presume = 0; sof = 0; tick = 0; ls = 0;
    repeat (2) @(negedge clk);
    // R10: all outputs low in reset
    chk({pad_release_o, clr_pchg_o, clr_sof_o, obs_ovr_o, obs_se0_o, pulldn_o,
         done_o, wake_flag_o, resume_to_o, sof_to_o} == '0, "R10",
        int'({obs_ovr_o, pulldn_o, done_o, wake_flag_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input bit lsv, input int kres, input int ksof,
                     input int div, input bit rst_first);
    int pt, st_t, sof_t, se0_t, wcnt, stage, s0, ph, nrel, nclr, ndone, guard;
    bit exp_sto, tk, sv, r8bad, hsbad, hung;
    pt = 0; st_t = 0; sof_t = 0; se0_t = 0; wcnt = 0; stage = 0; ph = 0;
    nrel = 0; nclr = 0; ndone = 0; guard = 0;
    exp_sto = 0; r8bad = 0; hsbad = 0; hung = 0;
    if (rst_first) do_reset();
    wake_set = 1; ls = lsv; presume = 0; sof = 1; tick = 0;
    @(negedge clk);
    wake_set = 0;
    // R9: flag raised by the set pulse
    chk(wake_flag_o, "R9", int'(wake_flag_o), 1);
    go = 1;
    while (1) begin
      @(negedge clk);
      go = 0;
      guard++;
      if (guard > 3000) begin hung = 1; break; end
      s0 = stage;
      if (guard == 1) begin
        // R11: start with flag clears sticky status
        chk(!resume_to_o && !sof_to_o, "R11", int'({resume_to_o, sof_to_o}), 0);
      end
      if (lsv && (obs_ovr_o || obs_se0_o)) r8bad = 1;
      if (!lsv && s0 <= 3 && !(obs_ovr_o && pulldn_o)) hsbad = 1;
      if (pad_release_o) nrel++;
      if (clr_pchg_o) nclr++;
      if (done_o) ndone++;
      tk = ((ph % div) == 0);
      ph++;
      case (s0)
        0: begin
          if (pad_release_o) begin
            stage = 1; st_t = 0;
          end else if (!done_o) begin
            presume = (pt >= kres);
            if (tk) pt++;
          end
        end
        1: begin
          if (clr_pchg_o || clr_sof_o) begin
            // R5: both clear strobes together
            chk(clr_pchg_o && clr_sof_o, "R5", int'({clr_pchg_o, clr_sof_o}), 3);
            // R4: settle interval in ticks
            chk(st_t == SET, "R4", st_t, SET);
            stage = 2; sof = 0; sof_t = 0;
          end else if (tk) begin
            st_t++;
          end
        end
        2: begin
          sv = (sof_t >= ksof);
          sof = sv;
          if (tk) begin
            if (sv) begin
              stage = 3; exp_sto = 0; wcnt = 0;
            end else if (sof_t == SFW - 1) begin
              stage = 3; exp_sto = 1; wcnt = 0;
            end
            sof_t++;
          end
        end
        3: begin
          wcnt++;
          if (wcnt == 2) begin
            // R6: frame wait outcome and exit timing
            chk(sof_to_o == exp_sto, "R6", int'(sof_to_o), int'(exp_sto));
            if (lsv) begin
              chk(done_o, "R6", int'(done_o), 1);
            end else begin
              chk(obs_se0_o, "R6", int'(obs_se0_o), 1);
              stage = 4; se0_t = 0;
              if (tk) se0_t++;
            end
          end
        end
        4: begin
          if (obs_se0_o) begin
            if (tk) se0_t++;
          end else begin
            // R7: override off first, pulldowns still forced
            chk(!obs_ovr_o && pulldn_o, "R7", int'({obs_ovr_o, pulldn_o}), 1);
            chk(se0_t == SEH, "R7", se0_t, SEH);
            stage = 5;
          end
        end
        default: begin
          // R7: pulldowns released with done
          chk(done_o && !pulldn_o, "R7", int'({done_o, pulldn_o}), 2);
        end
      endcase
      tick = tk;
      if (done_o) break;
    end
    chk(!hung, "R9", guard, 0);
    if (kres >= RES) begin
      // R2: abort without release
      chk(resume_to_o, "R2", int'(resume_to_o), 1);
      chk(nrel == 0 && nclr == 0, "R2", nrel + nclr, 0);
      chk(obs_ovr_o == !lsv && pulldn_o == !lsv, "R2", int'({obs_ovr_o, pulldn_o}),
          lsv ? 0 : 3);
    end else begin
      // R3: single release pulse
      chk(nrel == 1, "R3", nrel, 1);
      // R5: single clear
      chk(nclr == 1, "R5", nclr, 1);
      chk(!resume_to_o, "R2", int'(resume_to_o), 0);
    end
    if (lsv) chk(!r8bad, "R8", int'(r8bad), 0);
    else     chk(!hsbad, "R7", int'(hsbad), 0);
    presume = 0; sof = 0; tick = 0;
    @(negedge clk);
    // R9: single done, flag cleared
    chk(!done_o && !wake_flag_o && ndone == 1, "R9",
        int'({done_o, wake_flag_o}), 0);
  endtask

  initial begin
    total = 0; bad = 0;
    do_reset();

    // R1: start without flag
    go = 1;
    @(negedge clk);
    go = 0;
    chk(done_o, "R1", int'(done_o), 1);
    chk(!pad_release_o && !clr_pchg_o && !obs_ovr_o && !pulldn_o && !obs_se0_o,
        "R1", int'({pad_release_o, obs_ovr_o, pulldn_o}), 0);
    @(negedge clk);
    chk(!done_o, "R1", int'(done_o), 0);

    for (int lsv = 0; lsv < 2; lsv++) begin
      for (int dv = 1; dv <= 3; dv += 2) begin
        for (int kr = 0; kr <= RES; kr++) begin
          if (kr == RES) begin
            run(lsv[0], kr, 0, dv, 1'b1);
          end else begin
            for (int ks = 0; ks <= SFW; ks++) begin
              run(lsv[0], kr, ks, dv, 1'b1);
            end
          end
        end
      end
    end

    // R11: sticky timeout survives until next accepted start
    run(1'b0, RES, 0, 1, 1'b1);
    repeat (4) @(negedge clk);
    chk(resume_to_o, "R11", int'(resume_to_o), 1);
    run(1'b0, 0, 1, 1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule